// File: doc/BRIEF.md
# Linear-Window Indirect Memory Port

This block sits between a small controller core and its memories and turns a 16-bit indirect pointer into one physical access. The core presents a pointer, an addressing mode, a signed constant offset and, for writes, a data byte. The block forms the effective address, decides which memory region it falls in, performs the read or write, and hands back the updated pointer in the same cycle the access completes.

Three regions are resolved from the effective address. Addresses with bit 15 set go to program memory. Addresses from `LIN_BASE` upward with bit 15 clear form a hole-free linear window. Consecutive runs of `GPR_BYTES` window bytes are folded onto the general-purpose slice of successive `BANK_BYTES`-sized RAM banks. All lower addresses are plain banked addresses and reach the data RAM unchanged. Data RAM reads are combinational. The program memory port is registered, so a program read holds the core off for one extra cycle. Its port carries only the low byte lane of each program word.

Top module: `lin_ptr_port`

## Requirements
- R1: For an effective address `ea` with bit 15 clear and `ea >= LIN_BASE`, let `i = ea - LIN_BASE`. If `i < NUM_BANKS*GPR_BYTES`, the RAM address is `(i / GPR_BYTES)*BANK_BYTES + GPR_BASE + (i % GPR_BYTES)`. With the defaults, 0x2050 maps to 0x0A0 and 0x2370 maps to 0x5A0.
- R2: An effective address below `LIN_BASE` drives `ram_addr_o` with the same value unchanged.
- R3: An effective address with bit 15 set and `we_i` low is a program read. `rom_addr_o` is `ea[14:0]` and `rom_re_o` is high. `ready_o` is low in the first cycle of the request and high in the second. In the second cycle, `rdata_o` equals the byte that the ROM port returns for that address.
- R4: A data-RAM access completes in the cycle it is requested, with `ready_o` high. A read returns `ram_rdata_i` on `rdata_o`. A write raises `ram_we_o` for that cycle with `ram_wdata_o = wdata_i`. `rdata_o` is 0 for every write.
- R5: `mode_i` encodes the addressing mode:
  - 0: constant offset. `ea = ptr + sign-extended ofs_i` and the pointer is unchanged.
  - 1: post-increment. `ea = ptr` and the new pointer is `ptr+1`.
  - 2: post-decrement. `ea = ptr` and the new pointer is `ptr-1`.
  - 3: pre-increment. `ea = ptr_o = ptr+1`.
  - 4: pre-decrement. `ea = ptr_o = ptr-1`.
  - Codes 5 to 7 act as mode 0.
  - `ptr_o` carries the new pointer while `ready_o` is high.
- R6: All pointer and offset arithmetic wraps modulo 2^16.
- R7: A linear index at or beyond `NUM_BANKS*GPR_BYTES` completes in one cycle with `err_o` high, no `ram_we_o` and `rdata_o = 0`. The pointer is still updated.
- R8: A write whose effective address has bit 15 set completes in one cycle with `err_o` high. It raises neither `ram_we_o` nor `rom_re_o`.
- R9: With `req_i` low, and throughout reset, `ready_o`, `err_o` and `ram_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, held until `ready_o` |
| we_i | input | 1 | 1 = write, 0 = read |
| mode_i | input | 3 | Addressing mode (R5) |
| ofs_i | input | OFS_W | Signed constant offset |
| ptr_i | input | 16 | Current pointer value |
| wdata_i | input | 8 | Write data |
| ready_o | output | 1 | Access completes this cycle |
| rdata_o | output | 8 | Read data |
| err_o | output | 1 | Out-of-window or program-write error |
| ptr_o | output | 16 | Updated pointer, valid with `ready_o` |
| ram_addr_o | output | RAM_AW | Data RAM address |
| ram_we_o | output | 1 | Data RAM write enable |
| ram_wdata_o | output | 8 | Data RAM write data |
| ram_rdata_i | input | 8 | Data RAM read data, combinational |
| rom_re_o | output | 1 | Program memory read |
| rom_addr_o | output | ROM_AW | Program memory address |
| rom_rdata_i | input | 8 | Low byte of program word, one cycle after address |

## Verification
The bench builds the port with `NUM_BANKS = 4`, so the linear window ends at 0x213F. This puts the last mapped byte and the first rejected index a few bytes apart, next to bank crossings at 0x204F/0x2050. The other parameters keep their defaults. The pointer values 0x0000, 0x0002 and 0xFFFF, combined with each mode, drive the effective address across the 16-bit wrap into the program region, where the extra wait cycle is timed. A stride sweep over the whole reduced window compares every resolved RAM address and byte against an independent model of the folding.

// File: rtl/lin_ptr_pkg.sv
package lin_ptr_pkg;
  typedef enum logic [2:0] {
    AM_OFS      = 3'd0,
    AM_POST_INC = 3'd1,
    AM_POST_DEC = 3'd2,
    AM_PRE_INC  = 3'd3,
    AM_PRE_DEC  = 3'd4
  } am_e;

  typedef enum logic [1:0] {
    RG_BANKED = 2'd0,
    RG_LINEAR = 2'd1,
    RG_PROG   = 2'd2,
    RG_BAD    = 2'd3
  } region_e;
endpackage

// File: rtl/lin_ptr_agen.sv
module lin_ptr_agen
  import lin_ptr_pkg::*;
#(
  parameter int OFS_W = 6
) (
  input  logic [15:0]      ptr_i,
  input  logic [2:0]       mode_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic [15:0]      ea_o,
  output logic [15:0]      ptr_nxt_o
);
  logic [15:0] inc, dec, sofs;

  assign inc  = ptr_i + 16'd1;
  assign dec  = ptr_i - 16'd1;
  assign sofs = {{(16-OFS_W){ofs_i[OFS_W-1]}}, ofs_i};

  always_comb begin
    unique case (mode_i)
      AM_POST_INC: begin ea_o = ptr_i; ptr_nxt_o = inc; end
      AM_POST_DEC: begin ea_o = ptr_i; ptr_nxt_o = dec; end
      AM_PRE_INC:  begin ea_o = inc;   ptr_nxt_o = inc; end
      AM_PRE_DEC:  begin ea_o = dec;   ptr_nxt_o = dec; end
      default:     begin ea_o = ptr_i + sofs; ptr_nxt_o = ptr_i; end
    endcase
  end
endmodule

// File: rtl/lin_ptr_decode.sv
module lin_ptr_decode
  import lin_ptr_pkg::*;
#(
  parameter int NUM_BANKS  = 32,
  parameter int GPR_BYTES  = 80,
  parameter int GPR_BASE   = 32,
  parameter int BANK_BYTES = 128,
  parameter int LIN_BASE   = 8192,
  parameter int RAM_AW     = 13,
  parameter int ROM_AW     = 15
) (
  input  logic [15:0]       ea_i,
  output region_e           region_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic [ROM_AW-1:0] rom_addr_o
);
  localparam int LIN_LEN = NUM_BANKS * GPR_BYTES;

  logic [15:0] lin_idx;
  logic        in_lin, lin_ok;

  assign lin_idx = ea_i - 16'(LIN_BASE);
  assign in_lin  = (ea_i >= 16'(LIN_BASE));
  assign lin_ok  = (32'(lin_idx) < LIN_LEN);

  always_comb begin
    if (ea_i[15])     region_o = RG_PROG;
    else if (!in_lin) region_o = RG_BANKED;
    else if (lin_ok)  region_o = RG_LINEAR;
    else              region_o = RG_BAD;
  end

  // fold linear index onto the general-purpose slice of each bank
  always_comb begin
    if (in_lin)
      ram_addr_o = RAM_AW'((lin_idx / 16'(GPR_BYTES)) * 16'(BANK_BYTES)
                           + 16'(GPR_BASE) + (lin_idx % 16'(GPR_BYTES)));
    else
      ram_addr_o = RAM_AW'(ea_i);
  end

  assign rom_addr_o = ea_i[ROM_AW-1:0];
endmodule

// File: rtl/lin_ptr_port.sv
module lin_ptr_port
  import lin_ptr_pkg::*;
#(
  parameter int NUM_BANKS  = 32,
  parameter int GPR_BYTES  = 80,
  parameter int GPR_BASE   = 32,
  parameter int BANK_BYTES = 128,
  parameter int LIN_BASE   = 8192,
  parameter int OFS_W      = 6,
  parameter int RAM_AW     = 13,
  parameter int ROM_AW     = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [2:0]        mode_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [15:0]       ptr_i,
  input  logic [7:0]        wdata_i,
  output logic              ready_o,
  output logic [7:0]        rdata_o,
  output logic              err_o,
  output logic [15:0]       ptr_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic              ram_we_o,
  output logic [7:0]        ram_wdata_o,
  input  logic [7:0]        ram_rdata_i,
  output logic              rom_re_o,
  output logic [ROM_AW-1:0] rom_addr_o,
  input  logic [7:0]        rom_rdata_i
);
  logic [15:0] ea;
  region_e     region;
  logic        is_ram, rom_rd, bad, wait_q;
  logic [7:0]  rd_mux;

  lin_ptr_agen #(.OFS_W(OFS_W)) i_agen (
    .ptr_i    (ptr_i),
    .mode_i   (mode_i),
    .ofs_i    (ofs_i),
    .ea_o     (ea),
    .ptr_nxt_o(ptr_o)
  );

  lin_ptr_decode #(
    .NUM_BANKS (NUM_BANKS),
    .GPR_BYTES (GPR_BYTES),
    .GPR_BASE  (GPR_BASE),
    .BANK_BYTES(BANK_BYTES),
    .LIN_BASE  (LIN_BASE),
    .RAM_AW    (RAM_AW),
    .ROM_AW    (ROM_AW)
  ) i_decode (
    .ea_i      (ea),
    .region_o  (region),
    .ram_addr_o(ram_addr_o),
    .rom_addr_o(rom_addr_o)
  );

  assign is_ram = (region == RG_LINEAR) || (region == RG_BANKED);
  assign rom_rd = req_i && !we_i && (region == RG_PROG);
  assign bad    = (region == RG_BAD) || (we_i && (region == RG_PROG));

  // program read: first cycle issues address, second returns data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wait_q <= 1'b0;
    else         wait_q <= rom_rd && !wait_q;
  end

  assign ready_o     = req_i && (!rom_rd || wait_q);
  assign err_o       = req_i && bad;
  assign ram_we_o    = req_i && we_i && is_ram;
  assign ram_wdata_o = wdata_i;
  assign rom_re_o    = rom_rd;

  always_comb begin
    unique case (region)
      RG_PROG:   rd_mux = rom_rdata_i;
      RG_BAD:    rd_mux = 8'h00;
      default:   rd_mux = ram_rdata_i;
    endcase
  end

  assign rdata_o = (ready_o && !we_i) ? rd_mux : 8'h00;
endmodule

// File: rtl/lin_ptr_port_chk.sv
module lin_ptr_port_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        we_i,
  input logic [2:0]  mode_i,
  input logic [15:0] ptr_i,
  input logic        ready_o,
  input logic        err_o,
  input logic [15:0] ptr_o,
  input logic        ram_we_o,
  input logic        rom_re_o
);
  // R4
  ram_we_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> ready_o && !err_o);

  // R7
  err_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !ram_we_o && !rom_re_o && ready_o);

  // R8
  rom_read_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_re_o |-> !we_i);

  // R3
  wait_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !ready_o) |=> ready_o);

  // R3
  rom_late_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rom_re_o && ready_o) |-> $past(rom_re_o && !ready_o));

  // R5
  ofs_keeps_ptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && mode_i == 3'd0) |-> ptr_o == ptr_i);

  // R6
  post_inc_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && mode_i == 3'd1) |-> ptr_o == ptr_i + 16'd1);

  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> !ready_o && !err_o && !ram_we_o);
endmodule

bind lin_ptr_port lin_ptr_port_chk i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .mode_i  (mode_i),
  .ptr_i   (ptr_i),
  .ready_o (ready_o),
  .err_o   (err_o),
  .ptr_o   (ptr_o),
  .ram_we_o(ram_we_o),
  .rom_re_o(rom_re_o)
);

// File: tb/test_lin_ptr_port.sv
module test_lin_ptr_port;
  localparam int NB     = 4;
  localparam int OFS_W  = 6;
  localparam int RAM_AW = 13;
  localparam int ROM_AW = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [2:0] mode = 3'd0;
  logic [OFS_W-1:0] ofs = '0;
  logic [15:0] ptr = '0;
  logic [7:0]  wdata = '0;
  logic        ready, err, ram_we, rom_re;
  logic [7:0]  rdata, ram_wdata, ram_rdata, rom_q;
  logic [15:0] ptr_out;
  logic [RAM_AW-1:0] ram_addr;
  logic [ROM_AW-1:0] rom_addr;

  int checks = 0, errors = 0, n_done = 0, wait_cnt = 0;

  always #2 clk = ~clk;

  lin_ptr_port #(.NUM_BANKS(NB)) i_lin_ptr_port (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .mode_i(mode),
    .ofs_i(ofs), .ptr_i(ptr), .wdata_i(wdata), .ready_o(ready),
    .rdata_o(rdata), .err_o(err), .ptr_o(ptr_out), .ram_addr_o(ram_addr),
    .ram_we_o(ram_we), .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata),
    .rom_re_o(rom_re), .rom_addr_o(rom_addr), .rom_rdata_i(rom_q)
  );

  logic [7:0] mem [0:8191];
  function automatic logic [7:0] init_f(input int a);
    return 8'(a) + 8'((a >> 8) * 37);
  endfunction
  function automatic logic [7:0] rom_f(input logic [ROM_AW-1:0] a);
    return a[7:0] ^ 8'hC3;
  endfunction
  initial for (int k = 0; k < 8192; k++) mem[k] = init_f(k);
  assign ram_rdata = mem[ram_addr];
  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    rom_q <= rom_f(rom_addr);
  end

  typedef struct {
    int          kind;   // 0 ram, 1 rom, 2 error
    logic        we;
    int          addr;
    logic [7:0]  rd;
    logic [15:0] pn;
    int          lat;
    string       tag;
  } item_t;
  item_t sb[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // independent region model
  task automatic model(input logic [15:0] ea, output int kind, output int addr);
    int i;
    if (ea[15]) begin kind = 1; addr = int'(ea[14:0]); end
    else if (ea >= 16'h2000) begin
      i = int'(ea) - 8192;
      if (i < NB * 80) begin kind = 0; addr = (i / 80) * 128 + 32 + (i % 80); end
      else begin kind = 2; addr = 0; end
    end else begin kind = 0; addr = int'(ea); end
  endtask

  task automatic acc(input int md, input logic w, input logic [15:0] p,
                     input int o, input logic [7:0] wd, input string tag);
    item_t it;
    logic [15:0] ea, pn;
    int target;
    case (md)
      1: begin ea = p; pn = p + 16'd1; end
      2: begin ea = p; pn = p - 16'd1; end
      3: begin ea = p + 16'd1; pn = ea; end
      4: begin ea = p - 16'd1; pn = ea; end
      default: begin ea = p + 16'(o); pn = p; end
    endcase
    model(ea, it.kind, it.addr);
    if (w && it.kind == 1) it.kind = 2;
    it.we  = w && (it.kind == 0);
    it.rd  = w ? 8'h00 : (it.kind == 0) ? mem[it.addr]
           : (it.kind == 1) ? rom_f(ROM_AW'(it.addr)) : 8'h00;
    it.pn  = pn;
    it.lat = (!w && it.kind == 1) ? 1 : 0;
    it.tag = tag;
    sb.push_back(it);
    target = n_done + 1;
    mode = 3'(md); we = w; ptr = p; ofs = OFS_W'(o); wdata = wd; req = 1'b1;
    wait (n_done == target);
    @(posedge clk); #1;
    req = 1'b0;
  endtask

  // monitor: compare at negedge when an access completes
  always @(negedge clk) begin
    if (rst_n && req && !ready) wait_cnt++;
    if (rst_n && req && ready) begin
      item_t it;
      if (sb.size() == 0) chk(0, "R4", "unexpected completion", 1, 0);
      else begin
        it = sb.pop_front();
        chk(wait_cnt == it.lat, it.tag, "wait cycles", wait_cnt, it.lat);
        chk(err == (it.kind == 2), it.tag, "err", err, it.kind == 2);
        chk(ram_we == it.we, it.tag, "ram_we", ram_we, it.we);
        chk(rdata == it.rd, it.tag, "rdata", rdata, it.rd);
        chk(ptr_out == it.pn, it.tag, "ptr", ptr_out, it.pn);
        if (it.kind == 0)
          chk(int'(ram_addr) == it.addr, it.tag, "ram_addr", ram_addr, it.addr);
        if (it.kind == 1)
          chk(int'(rom_addr) == it.addr && rom_re, it.tag, "rom_addr", rom_addr, it.addr);
        if (it.kind == 2)
          chk(!rom_re, it.tag, "rom_re on error", rom_re, 0);
      end
      wait_cnt = 0;
      n_done++;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!ready && !err && !ram_we, "R9", "reset outputs", {ready, err, ram_we}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!ready && !err && !ram_we, "R9", "idle outputs", {ready, err, ram_we}, 0);
    @(posedge clk); #1;

    acc(0, 1'b0, 16'h0123, 0, 8'h00, "R2");      // banked read
    acc(0, 1'b0, 16'h1FFF, 0, 8'h00, "R2");      // top of banked space
    acc(1, 1'b1, 16'h2000, 0, 8'hA5, "R1");      // post-inc write, start of window
    acc(0, 1'b0, 16'h2000, 0, 8'h00, "R1");      // read back
    acc(3, 1'b0, 16'h204F, 0, 8'h00, "R5");      // pre-inc onto 0x2050 -> 0xA0
    acc(2, 1'b0, 16'h213F, 0, 8'h00, "R1");      // last mapped byte
    acc(4, 1'b0, 16'h2141, 0, 8'h00, "R5");      // pre-dec to 0x2140 -> error
    acc(0, 1'b1, 16'h2140, 0, 8'h77, "R7");      // write beyond window
    acc(1, 1'b0, 16'h3000, 0, 8'h00, "R7");
    acc(0, 1'b0, 16'h8123, 0, 8'h00, "R3");      // program read
    acc(1, 1'b0, 16'hC0FE, 0, 8'h00, "R3");
    acc(0, 1'b1, 16'h8010, 0, 8'h55, "R8");      // program write
    acc(1, 1'b0, 16'hFFFF, 0, 8'h00, "R6");      // post-inc wrap
    acc(4, 1'b0, 16'h0000, 0, 8'h00, "R6");      // pre-dec wrap
    acc(0, 1'b0, 16'h0002, -3, 8'h00, "R6");     // negative offset wrap
    acc(0, 1'b0, 16'h2000, 31, 8'h00, "R5");     // max positive offset
    acc(0, 1'b0, 16'h2040, -32, 8'h00, "R5");    // max negative offset
    acc(5, 1'b0, 16'h0100, 4, 8'h00, "R5");      // reserved mode acts as offset
    acc(2, 1'b1, 16'h0040, 0, 8'h3C, "R4");      // banked write
    acc(0, 1'b0, 16'h0040, 0, 8'h00, "R4");
    // writes across a bank seam, then read back
    for (int k = 0; k < 4; k++)
      acc(1, 1'b1, 16'h204E + 16'(k), 0, 8'(8'h90 + k), "R1");
    for (int k = 0; k < 4; k++)
      acc(0, 1'b0, 16'h204E + 16'(k), 0, 8'h00, "R1");
    chk(mem[128 + 32 + 1] == 8'h93, "R1", "seam byte in RAM", mem[161], 8'h93);
    // sweep whole window
    for (int k = 0; k < NB * 80; k += 7)
      acc(0, 1'b0, 16'h2000 + 16'(k), 0, 8'h00, "R1");

    repeat (2) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule